// File: doc/BRIEF.md
# Wristwatch Mode and Alarm Controller

This block is the control sequencer of a six-digit wristwatch. Conditioned pushbutton pulses drive it: a mode button, a select button and an adjust button, each high for a single clock. It also receives a one-second strobe and a half-second strobe. The mode button steps the primary mode through time display, alarm set and time set. The select button steps the field that is selected inside alarm set and inside time set. The adjust button acts according to the state. In time display it switches the hour format. In the first alarm-set submode it arms or disarms the alarm. In a submode where a field is selected, it raises an increment request for that field.

The controller holds the alarm-armed flag and the 12-hour flag. It produces a flash signal, and the selected field blinks because its blank output follows that flash signal. When the alarm is armed and the current hours and minutes equal the alarm hours and minutes, the controller sounds the alarm. The sound stops on a select press or after sixty one-second strobes. After it stops, it stays silent until the match ends. The digit counters, display decoders and button conditioning sit outside this block. They consume the increment requests, the seconds-hold request and the display-source select.

Top module: `watch_ctrl`

## Requirements
- R1: After the asynchronous reset, `mode_oh` is 7'b0000001 (time display), `fmt12` is 1, and `alarm_on`, `flash` and `alarm_snd` are 0.
- R2: The `mode_oh` bits are bit0 display, bit1 alarm flag, bit2 alarm hours, bit3 alarm minutes, bit4 time seconds, bit5 time hours and bit6 time minutes. A `btn_mode` pulse moves display to alarm flag, any alarm submode to time seconds, and any time submode to display. It takes priority over `btn_sel` in the same cycle.
- R3: A `btn_sel` pulse without `btn_mode` steps alarm flag to alarm hours, alarm hours to alarm minutes, and alarm minutes back to alarm flag. In time display it leaves the mode unchanged.
- R4: In the alarm-flag submode, `btn_adj` toggles `alarm_on`. Leaving that submode with `btn_sel` sets `alarm_on` to 1, whatever its value was.
- R5: A `btn_sel` pulse without `btn_mode` steps time seconds to time hours, time hours to time minutes, and time minutes back to time seconds.
- R6: In time display, `btn_adj` toggles `fmt12`. In every other mode, `btn_adj` leaves `fmt12` unchanged.
- R7: In the same cycle as `btn_adj`, `inc_hr`, `inc_min` and `inc_sec` are each high only while their field is selected (hours in bit2/bit5, minutes in bit3/bit6, seconds in bit4). `show_alarm` is high in the three alarm submodes.
- R8: `flash` inverts on the clock after each `tick_half`. `blank_hr`, `blank_min` and `blank_sec` each equal `flash` while their field is selected, and are 0 otherwise.
- R9: `alarm_snd` rises one clock after a cycle in which `alarm_on` is 1 and `cur_hr`/`cur_min` equal `alm_hr`/`alm_min`, unless the alarm has already been stopped during that match.
- R10: A `btn_sel` pulse silences a sounding alarm on the next clock. The alarm stays silent until the match ends, and a later match sounds it again.
- R11: A sounding alarm stops on the clock after the 60th `tick_sec` counted while it sounds.
- R12: `sec_hold` is high exactly while the time-minutes submode is active and `btn_adj` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| btn_mode | input | 1 | Mode button pulse |
| btn_sel | input | 1 | Select button pulse |
| btn_adj | input | 1 | Adjust button pulse |
| tick_sec | input | 1 | One-second strobe |
| tick_half | input | 1 | Half-second strobe |
| cur_hr | input | HR_W | Current hours |
| cur_min | input | MIN_W | Current minutes |
| alm_hr | input | HR_W | Alarm hours |
| alm_min | input | MIN_W | Alarm minutes |
| mode_oh | output | 7 | One-hot mode/submode |
| fmt12 | output | 1 | 12-hour display flag |
| alarm_on | output | 1 | Alarm armed flag |
| show_alarm | output | 1 | Display the alarm digits |
| flash | output | 1 | Blink phase |
| blank_hr | output | 1 | Blank the hour digits |
| blank_min | output | 1 | Blank the minute digits |
| blank_sec | output | 1 | Blank the second digits |
| inc_hr | output | 1 | Increment hours request |
| inc_min | output | 1 | Increment minutes request |
| inc_sec | output | 1 | Increment seconds request |
| sec_hold | output | 1 | Suppress seconds advance |
| alarm_snd | output | 1 | Alarm sounder |

## Verification
The assertions check on every cycle that exactly one mode bit is high and that no two increment requests rise together. They also check that the mode button leaves display for the alarm-flag submode, that leaving the alarm-flag submode arms the alarm, and that the flash signal inverts after each half-second strobe. For the sounder, they check that it needs a match on the cycle before, that it falls after a select press, and that it never outlasts sixty counted seconds. Only the bench's scenarios can show the full order of submodes and the hour-format toggle. The same holds for the rule that a stopped alarm stays quiet until its minute passes and then sounds again on a new match. The bench shows these against a behavioural model that it compares on every clock.

// File: rtl/watch_pkg.sv
package watch_pkg;
  typedef enum logic [2:0] {
    ST_SHOW    = 3'd0,
    ST_AL_FLAG = 3'd1,
    ST_AL_HR   = 3'd2,
    ST_AL_MIN  = 3'd3,
    ST_TS_SEC  = 3'd4,
    ST_TS_HR   = 3'd5,
    ST_TS_MIN  = 3'd6
  } wmode_t;

  localparam int NUM_MODES = 7;

  // Mode button wins; select only rotates inside a set group.
  function automatic wmode_t next_mode(input wmode_t cur, input logic b_mode,
                                       input logic b_sel);
    wmode_t n;
    n = cur;
    if (b_mode) begin
      case (cur)
        ST_SHOW:                         n = ST_AL_FLAG;
        ST_AL_FLAG, ST_AL_HR, ST_AL_MIN: n = ST_TS_SEC;
        default:                         n = ST_SHOW;
      endcase
    end else if (b_sel) begin
      case (cur)
        ST_AL_FLAG: n = ST_AL_HR;
        ST_AL_HR:   n = ST_AL_MIN;
        ST_AL_MIN:  n = ST_AL_FLAG;
        ST_TS_SEC:  n = ST_TS_HR;
        ST_TS_HR:   n = ST_TS_MIN;
        ST_TS_MIN:  n = ST_TS_SEC;
        default:    n = cur;
      endcase
    end
    return n;
  endfunction

  function automatic logic [NUM_MODES-1:0] mode_onehot(input wmode_t m);
    return NUM_MODES'(1) << m;
  endfunction
endpackage

// File: rtl/watch_seq.sv
module watch_seq
  import watch_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   btn_mode,
  input  logic   btn_sel,
  input  logic   btn_adj,
  input  logic   tick_half,
  output wmode_t mode,
  output logic   fmt12,
  output logic   alarm_on,
  output logic   flash
);
  wmode_t mode_nx;
  logic   arm_force;
  logic   arm_toggle;
  logic   fmt_toggle;

  assign mode_nx    = next_mode(mode, btn_mode, btn_sel);
  assign arm_force  = (mode == ST_AL_FLAG) && btn_sel && !btn_mode;
  assign arm_toggle = (mode == ST_AL_FLAG) && btn_adj;
  assign fmt_toggle = (mode == ST_SHOW) && btn_adj;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode     <= ST_SHOW;
      fmt12    <= 1'b1;
      alarm_on <= 1'b0;
      flash    <= 1'b0;
    end else begin
      mode <= mode_nx;
      if (arm_force)       alarm_on <= 1'b1;
      else if (arm_toggle) alarm_on <= !alarm_on;
      if (fmt_toggle)      fmt12 <= !fmt12;
      if (tick_half)       flash <= !flash;
    end
  end
endmodule

// File: rtl/watch_field.sv
module watch_field
  import watch_pkg::*;
(
  input  wmode_t mode,
  input  logic   flash,
  input  logic   btn_adj,
  output logic   show_alarm,
  output logic   blank_hr,
  output logic   blank_min,
  output logic   blank_sec,
  output logic   inc_hr,
  output logic   inc_min,
  output logic   inc_sec,
  output logic   sec_hold
);
  logic sel_hr, sel_min, sel_sec;

  assign sel_hr     = (mode == ST_AL_HR)  || (mode == ST_TS_HR);
  assign sel_min    = (mode == ST_AL_MIN) || (mode == ST_TS_MIN);
  assign sel_sec    = (mode == ST_TS_SEC);
  assign show_alarm = (mode == ST_AL_FLAG) || (mode == ST_AL_HR) || (mode == ST_AL_MIN);

  assign blank_hr  = flash & sel_hr;
  assign blank_min = flash & sel_min;
  assign blank_sec = flash & sel_sec;
  assign inc_hr    = btn_adj & sel_hr;
  assign inc_min   = btn_adj & sel_min;
  assign inc_sec   = btn_adj & sel_sec;
  assign sec_hold  = btn_adj & (mode == ST_TS_MIN);
endmodule

// File: rtl/watch_alarm.sv
module watch_alarm #(
  parameter int HR_W  = 5,
  parameter int MIN_W = 6,
  parameter int TICKS = 60
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alarm_on,
  input  logic [HR_W-1:0]  cur_hr,
  input  logic [MIN_W-1:0] cur_min,
  input  logic [HR_W-1:0]  alm_hr,
  input  logic [MIN_W-1:0] alm_min,
  input  logic             btn_sel,
  input  logic             tick_sec,
  output logic             match,
  output logic             alarm_snd
);
  localparam int CW = $clog2(TICKS + 1);

  logic [CW-1:0] secs;
  logic          spent;
  logic          last_tick;

  assign match     = alarm_on && (cur_hr == alm_hr) && (cur_min == alm_min);
  assign last_tick = tick_sec && (secs == CW'(TICKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alarm_snd <= 1'b0;
      spent     <= 1'b0;
      secs      <= '0;
    end else if (!match) begin
      alarm_snd <= 1'b0;
      spent     <= 1'b0;
      secs      <= '0;
    end else if (alarm_snd) begin
      if (btn_sel || last_tick) begin
        alarm_snd <= 1'b0;
        spent     <= 1'b1;
      end else if (tick_sec) begin
        secs <= secs + 1'b1;
      end
    end else if (!spent) begin
      alarm_snd <= 1'b1;
      secs      <= '0;
    end
  end
endmodule

// File: rtl/watch_ctrl.sv
module watch_ctrl
  import watch_pkg::*;
#(
  parameter int HR_W         = 5,
  parameter int MIN_W        = 6,
  parameter int ALARM_TICKS  = 60
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             btn_mode,
  input  logic             btn_sel,
  input  logic             btn_adj,
  input  logic             tick_sec,
  input  logic             tick_half,
  input  logic [HR_W-1:0]  cur_hr,
  input  logic [MIN_W-1:0] cur_min,
  input  logic [HR_W-1:0]  alm_hr,
  input  logic [MIN_W-1:0] alm_min,
  output logic [6:0]       mode_oh,
  output logic             fmt12,
  output logic             alarm_on,
  output logic             show_alarm,
  output logic             flash,
  output logic             blank_hr,
  output logic             blank_min,
  output logic             blank_sec,
  output logic             inc_hr,
  output logic             inc_min,
  output logic             inc_sec,
  output logic             sec_hold,
  output logic             alarm_snd
);
  wmode_t mode;
  logic   alm_match;

  watch_seq u_seq (
    .clk(clk), .rst_n(rst_n), .btn_mode(btn_mode), .btn_sel(btn_sel),
    .btn_adj(btn_adj), .tick_half(tick_half), .mode(mode), .fmt12(fmt12),
    .alarm_on(alarm_on), .flash(flash)
  );

  watch_field u_field (
    .mode(mode), .flash(flash), .btn_adj(btn_adj), .show_alarm(show_alarm),
    .blank_hr(blank_hr), .blank_min(blank_min), .blank_sec(blank_sec),
    .inc_hr(inc_hr), .inc_min(inc_min), .inc_sec(inc_sec), .sec_hold(sec_hold)
  );

  watch_alarm #(.HR_W(HR_W), .MIN_W(MIN_W), .TICKS(ALARM_TICKS)) u_alarm (
    .clk(clk), .rst_n(rst_n), .alarm_on(alarm_on), .cur_hr(cur_hr),
    .cur_min(cur_min), .alm_hr(alm_hr), .alm_min(alm_min), .btn_sel(btn_sel),
    .tick_sec(tick_sec), .match(alm_match), .alarm_snd(alarm_snd)
  );

  assign mode_oh = mode_onehot(mode);
endmodule

// File: rtl/watch_ctrl_chk.sv
module watch_ctrl_chk #(
  parameter int TICKS = 60
) (
  input logic       clk,
  input logic       rst_n,
  input logic       btn_mode,
  input logic       btn_sel,
  input logic       tick_sec,
  input logic       tick_half,
  input logic [6:0] mode_oh,
  input logic       alarm_on,
  input logic       flash,
  input logic       inc_hr,
  input logic       inc_min,
  input logic       inc_sec,
  input logic       alm_match,
  input logic       alarm_snd
);
  localparam int CW = $clog2(TICKS + 1);
  logic [CW:0] snd_secs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   snd_secs <= '0;
    else if (!alarm_snd)          snd_secs <= '0;
    else if (tick_sec)            snd_secs <= snd_secs + 1'b1;
  end

  p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(mode_oh) == 1);
  p_show_to_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_oh[0] && btn_mode) |=> mode_oh[1]);
  p_arm_force_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_oh[1] && btn_sel && !btn_mode) |=> alarm_on);
  p_inc_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({inc_hr, inc_min, inc_sec}));
  p_flash_flip_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tick_half |=> (flash != $past(flash)));
  p_snd_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_snd) |-> $past(alm_match));
  p_sel_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_snd && btn_sel) |=> !alarm_snd);
  p_timeout_r11: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_snd |-> (snd_secs < (CW+1)'(TICKS)));
endmodule

bind watch_ctrl watch_ctrl_chk #(.TICKS(ALARM_TICKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .btn_mode(btn_mode), .btn_sel(btn_sel),
  .tick_sec(tick_sec), .tick_half(tick_half), .mode_oh(mode_oh),
  .alarm_on(alarm_on), .flash(flash), .inc_hr(inc_hr), .inc_min(inc_min),
  .inc_sec(inc_sec), .alm_match(alm_match), .alarm_snd(alarm_snd)
);

// File: tb/tb_watch_ctrl.sv
`timescale 1ns/1ps
module tb_watch_ctrl;
  logic clk = 0;
  logic rst_n = 0;
  logic btn_mode = 0, btn_sel = 0, btn_adj = 0, tick_sec = 0, tick_half = 0;
  logic [4:0] cur_hr = 5'd7, alm_hr = 5'd6;
  logic [5:0] cur_min = 6'd30, alm_min = 6'd30;
  logic [6:0] mode_oh;
  logic fmt12, alarm_on, show_alarm, flash, blank_hr, blank_min, blank_sec;
  logic inc_hr, inc_min, inc_sec, sec_hold, alarm_snd;

  always #5 clk = ~clk;

  watch_ctrl dut (.*);

  int n_chk = 0, n_bad = 0;
  // reference model state
  int m_md = 0, m_f12 = 1, m_aon = 0, m_fl = 0, m_snd = 0, m_spent = 0, m_cnt = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  function automatic bit sel(input int a, input int b);
    return (m_md == a) || (m_md == b);
  endfunction

  task automatic compare_all();
    chk("R2 R3 R5 mode", mode_oh, 1 << m_md);
    chk("R4 alarm_on", alarm_on, m_aon);
    chk("R6 fmt12", fmt12, m_f12);
    chk("R8 flash", flash, m_fl);
    chk("R8 blank_hr", blank_hr, m_fl && sel(2, 5));
    chk("R8 blank_min", blank_min, m_fl && sel(3, 6));
    chk("R8 blank_sec", blank_sec, m_fl && m_md == 4);
    chk("R7 inc_hr", inc_hr, btn_adj && sel(2, 5));
    chk("R7 inc_min", inc_min, btn_adj && sel(3, 6));
    chk("R7 inc_sec", inc_sec, btn_adj && m_md == 4);
    chk("R7 show_alarm", show_alarm, m_md >= 1 && m_md <= 3);
    chk("R12 sec_hold", sec_hold, btn_adj && m_md == 6);
    chk("R9 R10 R11 alarm_snd", alarm_snd, m_snd);
  endtask

  // model update using inputs present at the edge
  task automatic model_edge(input bit b0, b1, b2, th, ts);
    int old = m_md;
    bit hit = m_aon && cur_hr == alm_hr && cur_min == alm_min;
    if (b0) m_md = (old == 0) ? 1 : (old <= 3) ? 4 : 0;
    else if (b1) begin
      if (old >= 1 && old <= 3) m_md = (old == 3) ? 1 : old + 1;
      else if (old >= 4) m_md = (old == 6) ? 4 : old + 1;
    end
    if (old == 1 && b2) m_aon = !m_aon;
    if (old == 1 && b1 && !b0) m_aon = 1;
    if (old == 0 && b2) m_f12 = !m_f12;
    if (th) m_fl = !m_fl;
    if (!hit) begin m_snd = 0; m_spent = 0; m_cnt = 0; end
    else if (m_snd) begin
      if (b1 || (ts && m_cnt == 59)) begin m_snd = 0; m_spent = 1; end
      else if (ts) m_cnt++;
    end else if (!m_spent) begin m_snd = 1; m_cnt = 0; end
  endtask

  task automatic cyc(input bit b0, b1, b2, th, ts);
    btn_mode = b0; btn_sel = b1; btn_adj = b2; tick_half = th; tick_sec = ts;
    @(posedge clk);
    model_edge(b0, b1, b2, th, ts);
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    @(negedge clk);
    // R1 reset state
    chk("R1 mode", mode_oh, 1);
    chk("R1 fmt12", fmt12, 1);
    chk("R1 alarm_on", alarm_on, 0);
    chk("R1 flash", flash, 0);
    chk("R1 alarm_snd", alarm_snd, 0);
    @(negedge clk); rst_n = 1;
    idle(2);
    // R6 format toggle in display; R3 select ignored in display
    cyc(0, 0, 1, 0, 0); cyc(0, 1, 0, 0, 0);
    chk("R3 sel ignored in display", mode_oh, 1);
    chk("R6 fmt toggled", fmt12, 0);
    // R2 into alarm flag; R4 toggle twice, then force by select
    cyc(1, 0, 0, 0, 0);
    cyc(0, 0, 1, 0, 0); cyc(0, 0, 1, 0, 0);
    chk("R4 double toggle", alarm_on, 0);
    cyc(0, 1, 0, 0, 0);
    chk("R4 forced arm", alarm_on, 1);
    // R7 increments, R8 flash/blank
    cyc(0, 0, 1, 1, 0); cyc(0, 1, 1, 0, 0); cyc(0, 0, 1, 1, 0);
    chk("R6 fmt unchanged in set", fmt12, 0);
    cyc(0, 1, 0, 0, 0);
    chk("R3 wraps to flag", mode_oh, 7'b0000010);
    cyc(0, 1, 0, 0, 0); cyc(0, 1, 0, 0, 0);
    // R2 priority over select
    cyc(1, 1, 0, 0, 0);
    chk("R2 mode beats sel", mode_oh, 7'b0010000);
    // R5 time-set cycle with adjust, R12 hold
    for (int i = 0; i < 4; i++) begin cyc(0, 0, 1, i % 2, 0); cyc(0, 1, 0, 0, 0); end
    cyc(0, 0, 1, 0, 0);
    cyc(1, 0, 0, 0, 0);
    chk("R2 back to display", mode_oh, 1);
    // R9 alarm start on match (alarm armed above)
    alm_hr = 5'd7; cyc(0, 0, 0, 0, 0); cyc(0, 0, 0, 0, 0);
    chk("R9 sounding", alarm_snd, 1);
    for (int i = 0; i < 5; i++) begin cyc(0, 0, 0, 0, 1); cyc(0, 0, 0, 0, 0); end
    // R10 cancel, stays silent through match
    cyc(0, 1, 0, 0, 0); idle(4);
    chk("R10 silent after cancel", alarm_snd, 0);
    cur_min = 6'd31; idle(2); cur_min = 6'd30; idle(2);
    chk("R10 rearmed", alarm_snd, 1);
    // R11 timeout after 60 ticks
    for (int i = 0; i < 59; i++) begin cyc(0, 0, 0, 0, 1); cyc(0, 0, 0, 0, 0); end
    chk("R11 still sounding at 59", alarm_snd, 1);
    cyc(0, 0, 0, 0, 1);
    chk("R11 stopped at 60", alarm_snd, 0);
    idle(5);
    chk("R11 no retrigger", alarm_snd, 0);
    finish_run();
  end
endmodule